// File: doc/BRIEF.md
# Dual-Side Integrate/Measure Sequencer

This block sequences a front end in which every input has two integrators, side A and side B. While one side integrates, the other side is measured, reset and auto-zeroed (m/r/az). The block reacts to the level of a single convert input. A high level integrates on side A and a low level integrates on side B. The duration of each m/r/az cycle comes from an internal counter of clock periods. The block reports which side integrates, when an m/r/az cycle starts on each side, whether the measurement engine is busy, and when converted data becomes ready.

There are eight states, numbered 1 to 8, and they are arranged as two mirror halves. States 3 to 6 form the continuous mode, in which the idle side is always ready before convert changes. If convert changes while a measurement is still running, the block falls back to a non-continuous path. In that path the inputs are grounded and the block waits for the measurements to finish. It then prepares the correct side and resumes. Whatever the convert pattern, integration never repeats a side twice in a row.

Top module: `dual_int_seq`

## Requirements
- R1: While reset is asserted, state_o reads 7 (state 8), busy_o and all pulses are low, and gnd_o is high. On the first clock edge after release, the state becomes 1 (state_o=0) if conv_i is high and 8 (state_o=7) if conv_i is low. state_o always carries the state number minus one.
- R2: In continuous operation, state 3 moves to 4 when conv_i is low and state 6 moves to 5 when conv_i is high. State 4 moves to 5 on conv_i high, and state 5 moves to 4 on conv_i low, but only if busy_o is low at that time.
- R3: Entering state 4 (from 3 or 5) requests an m/r/az cycle on side A. Entering state 5 (from 6 or 4) requests one on side B. Each started cycle shows as a one-cycle pulse on mraz_start_a_o or mraz_start_b_o. When the engine is idle, the pulse comes in the first cycle of the new state.
- R4: If conv_i goes high in state 4 while busy_o is high, the next state is 1. If conv_i goes low in state 5 while busy_o is high, the next state is 8. The request for the other side is queued and starts exactly MRAZ_LEN cycles after the running one started.
- R5: States 1 and 8 hold, whatever conv_i does, until busy_o is low, and then move to 2 and 7 respectively. State 2 waits for conv_i high before moving to 3. State 7 waits for conv_i low before moving to 6. State 3 is never occupied while busy_o is high.
- R6: gnd_o is high in states 1, 2, 7 and 8 and low in states 3 to 6.
- R7: int_side_o (0 = A, 1 = B) gives the side that is integrating, or the side that will integrate next. It is 0 in states 1, 2, 3 and 5, and 1 in states 4, 6, 7 and 8.
- R8: busy_o rises together with an m/r/az start pulse. It stays high for MRAZ_LEN clock cycles per measurement, including a queued one. MRAZ_LEN is 1552 internal periods in low-power mode and 1612 in high-speed mode, multiplied by CLK_DIV.
- R9: drdy_o is a one-cycle pulse that appears DRDY_LEN clock cycles after each m/r/az start pulse. DRDY_LEN is 1382 internal periods, multiplied by CLK_DIV.
- R10: Successive integrating states (3 to 6) always alternate between side A and side B, for any conv_i pattern.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| conv_i | input | 1 | Convert level, synchronous to clk_i; 1 = integrate A, 0 = integrate B |
| state_o | output | 3 | Current state number minus one |
| int_side_o | output | 1 | Integrating or next side, 0 = A, 1 = B |
| gnd_o | output | 1 | Inputs grounded (non-continuous states) |
| mraz_start_a_o | output | 1 | One-cycle pulse, m/r/az starts on side A |
| mraz_start_b_o | output | 1 | One-cycle pulse, m/r/az starts on side B |
| busy_o | output | 1 | Measurement engine running or holding a queued request |
| drdy_o | output | 1 | One-cycle data-ready pulse |

## Verification
The hardest condition to reach is a convert change that arrives mid-measurement, because that forces the fallback state. The queued second measurement and the grounded hold must then be observed while convert keeps toggling. The stimulus reaches this condition by flipping convert a few hundred cycles after an m/r/az start. It then toggles convert again inside state 1 or 8, and leaves convert at the wrong level when busy clears. This shows that states 2 and 7 wait for the correct level. Long convert periods cover the clean continuous ping-pong, and a scoreboard checks the order of states, start sides and busy lengths.

// File: rtl/dis_pkg.sv
package dis_pkg;
  typedef enum logic [2:0] {
    ST1 = 3'd0, ST2 = 3'd1, ST3 = 3'd2, ST4 = 3'd3,
    ST5 = 3'd4, ST6 = 3'd5, ST7 = 3'd6, ST8 = 3'd7
  } st_e;

  function automatic logic is_ncont(st_e s);
    return (s == ST1) || (s == ST2) || (s == ST7) || (s == ST8);
  endfunction

  // side integrating now or next: 0 = A, 1 = B
  function automatic logic side_of(st_e s);
    return (s == ST4) || (s == ST6) || (s == ST7) || (s == ST8);
  endfunction
endpackage

// File: rtl/dis_tick.sv
module dis_tick #(
  parameter int unsigned DIV = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                    cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = (cnt_q == LAST);
endmodule

// File: rtl/dis_engine.sv
module dis_engine #(
  parameter int unsigned MRAZ_LEN = 1552,
  parameter int unsigned DRDY_LEN = 1382
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       req_a_i,
  input  logic       req_b_i,
  output logic       busy_o,
  output logic [1:0] start_o,
  output logic       drdy_o
);
  localparam int unsigned CW = $clog2(MRAZ_LEN + 1);
  localparam int unsigned DW = $clog2(DRDY_LEN + 1);

  logic          run_q, pend_q, pend_side_q, dact_q, drdy_q;
  logic [CW-1:0] cnt_q;
  logic [DW-1:0] dcnt_q;
  logic [1:0]    start_q;

  logic req, req_side, done, idle_now, launch_req, launch_pend, launch, launch_side, queue_req;

  assign req         = req_a_i | req_b_i;
  assign req_side    = req_b_i;
  assign done        = run_q & tick_i & (cnt_q == '0);
  assign idle_now    = ~run_q | (done & ~pend_q);
  assign launch_req  = req & idle_now;
  assign launch_pend = done & pend_q;
  assign launch      = launch_req | launch_pend;
  assign launch_side = launch_pend ? pend_side_q : req_side;
  assign queue_req   = req & ~idle_now;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else if (launch) begin
      run_q <= 1'b1;
      cnt_q <= CW'(MRAZ_LEN - 1);
    end else if (done) begin
      run_q <= 1'b0;
    end else if (run_q && tick_i) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q      <= 1'b0;
      pend_side_q <= 1'b0;
    end else if (queue_req) begin
      pend_q      <= 1'b1;
      pend_side_q <= req_side;
    end else if (launch_pend) begin
      pend_q <= 1'b0;
    end
  end

  for (genvar s = 0; s < 2; s++) begin : g_side
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) start_q[s] <= 1'b0;
      else         start_q[s] <= launch && (launch_side == 1'(s));
    end
  end

  // data-ready delay counted from each launch
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dact_q <= 1'b0;
      dcnt_q <= '0;
      drdy_q <= 1'b0;
    end else begin
      drdy_q <= 1'b0;
      if (launch) begin
        dact_q <= 1'b1;
        dcnt_q <= DW'(DRDY_LEN - 1);
      end else if (dact_q && tick_i) begin
        if (dcnt_q == '0) begin
          dact_q <= 1'b0;
          drdy_q <= 1'b1;
        end else begin
          dcnt_q <= dcnt_q - 1'b1;
        end
      end
    end
  end

  assign busy_o  = run_q | pend_q;
  assign start_o = start_q;
  assign drdy_o  = drdy_q;

  p_one_pend_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_a_i || req_b_i) |-> !pend_q);
  p_req_excl_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_a_i && req_b_i));
  p_start_onehot_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(start_q));
  p_drdy_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drdy_q |=> !drdy_q);
endmodule

// File: rtl/dis_fsm.sv
module dis_fsm
  import dis_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic conv_i,
  input  logic busy_i,
  output st_e  state_o,
  output logic req_a_o,
  output logic req_b_o
);
  st_e  st_q, st_d;
  logic boot_q;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST1: if (!busy_i) st_d = ST2;
      ST2: if (conv_i)  st_d = ST3;
      ST3: if (!conv_i) st_d = ST4;
      ST4: if (conv_i)  st_d = busy_i ? ST1 : ST5;
      ST5: if (!conv_i) st_d = busy_i ? ST8 : ST4;
      ST6: if (conv_i)  st_d = ST5;
      ST7: if (!conv_i) st_d = ST6;
      ST8: if (!busy_i) st_d = ST7;
      default: st_d = ST8;
    endcase
    if (boot_q) st_d = conv_i ? ST1 : ST8;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST8;
      boot_q <= 1'b1;
    end else begin
      st_q   <= st_d;
      boot_q <= 1'b0;
    end
  end

  // idle-side measurement requested on leaving an integrate phase
  assign req_a_o = !boot_q && !conv_i && ((st_q == ST3) || (st_q == ST5));
  assign req_b_o = !boot_q &&  conv_i && ((st_q == ST6) || (st_q == ST4));
  assign state_o = st_q;

  p_hold_s1_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST1 && busy_i && !boot_q) |=> st_q == ST1);
  p_hold_s8_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST8 && busy_i && !boot_q) |=> st_q == ST8);
  p_fall_s4_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST4 && conv_i && busy_i && !boot_q) |=> st_q == ST1);
  p_fall_s5_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST5 && !conv_i && busy_i && !boot_q) |=> st_q == ST8);
  p_enter_s3_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST3 && $past(st_q) != ST3) |-> $past(st_q) == ST2);
endmodule

// File: rtl/dual_int_seq.sv
module dual_int_seq
  import dis_pkg::*;
#(
  parameter bit          HIGH_SPEED = 1'b0,
  parameter int unsigned CLK_DIV    = 1,
  parameter int unsigned MRAZ_LP    = 1552,
  parameter int unsigned MRAZ_HS    = 1612,
  parameter int unsigned DRDY_BASE  = 1382
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       conv_i,
  output logic [2:0] state_o,
  output logic       int_side_o,
  output logic       gnd_o,
  output logic       mraz_start_a_o,
  output logic       mraz_start_b_o,
  output logic       busy_o,
  output logic       drdy_o
);
  localparam int unsigned MRAZ_TICKS = HIGH_SPEED ? MRAZ_HS : MRAZ_LP;

  logic       tick, busy, req_a, req_b, drdy;
  logic [1:0] start;
  st_e        st;

  dis_tick #(.DIV(CLK_DIV)) i_tick (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_o(tick)
  );

  dis_engine #(.MRAZ_LEN(MRAZ_TICKS), .DRDY_LEN(DRDY_BASE)) i_engine (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick),
    .req_a_i(req_a),
    .req_b_i(req_b),
    .busy_o (busy),
    .start_o(start),
    .drdy_o (drdy)
  );

  dis_fsm i_fsm (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .conv_i (conv_i),
    .busy_i (busy),
    .state_o(st),
    .req_a_o(req_a),
    .req_b_o(req_b)
  );

  assign state_o        = st;
  assign int_side_o     = side_of(st);
  assign gnd_o          = is_ncont(st);
  assign mraz_start_a_o = start[0];
  assign mraz_start_b_o = start[1];
  assign busy_o         = busy;
  assign drdy_o         = drdy;

  p_s3_idle_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == ST3) |-> !busy);
  p_start_busy_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start != 2'b00) |-> busy);
endmodule

// File: tb/test_dual_int_seq.sv
`timescale 1ns/1ps
module test_dual_int_seq;
  localparam int MRAZ = 1552;
  localparam int DRDY = 1382;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic conv = 1'b0;
  logic [2:0] state_o;
  logic int_side_o, gnd_o, start_a, start_b, busy_o, drdy_o;

  always #4 clk = ~clk;

  dual_int_seq i_dual_int_seq (
    .clk_i(clk), .rst_ni(rst_n), .conv_i(conv),
    .state_o(state_o), .int_side_o(int_side_o), .gnd_o(gnd_o),
    .mraz_start_a_o(start_a), .mraz_start_b_o(start_b),
    .busy_o(busy_o), .drdy_o(drdy_o)
  );

  int n_chk = 0, n_err = 0;
  int cyc = 0;
  bit finished = 0;
  int exp_st[$];
  int exp_start[$];
  int exp_busy[$];
  int prev_st = 8, last_side = -1, cur, e, sd;
  int last_start = 0, start_gap = 0, busy_rise = 0;
  bit busy_prev = 0, drdy_wait = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input string tag, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_err++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  function automatic int ncont(input int s);
    return (s == 1 || s == 2 || s == 7 || s == 8) ? 1 : 0;
  endfunction

  function automatic int side_exp(input int s);
    return (s == 4 || s == 6 || s == 7 || s == 8) ? 1 : 0;
  endfunction

  // monitor / scoreboard
  always @(negedge clk) begin
    if (!rst_n) begin
      prev_st = 8; last_side = -1; busy_prev = 0; drdy_wait = 0;
    end else begin
      cur = int'(state_o) + 1;
      if (cur != prev_st) begin
        if (exp_st.size() == 0) check("R2 unexpected state", cur, -1);
        else begin e = exp_st.pop_front(); check("R2 state order", cur, e); end
        check("R6 grounding", int'(gnd_o), ncont(cur));
        check("R7 side output", int'(int_side_o), side_exp(cur));
        if (cur >= 3 && cur <= 6) begin
          sd = (cur == 3 || cur == 5) ? 0 : 1;
          if (last_side >= 0) check("R10 alternation", int'(sd != last_side), 1);
          last_side = sd;
        end
        prev_st = cur;
      end
      if (start_a || start_b) begin
        check("R3 single start", int'(start_a && start_b), 0);
        if (exp_start.size() == 0) check("R3 unexpected start", int'(start_b), -1);
        else begin e = exp_start.pop_front(); check("R3 start side", int'(start_b), e); end
        start_gap = cyc - last_start;
        last_start = cyc;
        drdy_wait = 1;
      end
      if (drdy_o) begin
        check("R9 drdy expected", int'(drdy_wait), 1);
        check("R9 drdy delay", cyc - last_start, DRDY);
        drdy_wait = 0;
      end
      if (busy_o && !busy_prev) busy_rise = cyc;
      if (!busy_o && busy_prev) begin
        if (exp_busy.size() == 0) check("R8 unexpected busy", cyc - busy_rise, -1);
        else begin e = exp_busy.pop_front(); check("R8 busy length", cyc - busy_rise, e); end
      end
      busy_prev = busy_o;
    end
  end

  task automatic hold(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_conv(input logic v);
    @(negedge clk) conv = v;
  endtask

  task automatic step(input int st, input int side, input int blen, input logic v);
    exp_st.push_back(st);
    if (side >= 0) exp_start.push_back(side);
    if (blen > 0) exp_busy.push_back(blen);
    set_conv(v);
  endtask

  task automatic drained(input string tag);
    check({tag, " states drained"}, exp_st.size(), 0);
    check({tag, " starts drained"}, exp_start.size(), 0);
    check({tag, " busy drained"}, exp_busy.size(), 0);
  endtask

  task automatic do_reset(input logic lvl);
    @(negedge clk) rst_n = 1'b0;
    conv = lvl;
    hold(3);
    check("R1 reset state", int'(state_o), 7);
    check("R1 reset busy", int'(busy_o), 0);
    check("R1 reset gnd", int'(gnd_o), 1);
    check("R1 reset pulses", int'(start_a | start_b | drdy_o), 0);
    exp_st.delete(); exp_start.delete(); exp_busy.delete();
  endtask

  task automatic release_rst(input int exp_state);
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
    check("R1 start state", int'(state_o), exp_state);
  endtask

  initial begin
    // A: power-up low, continuous 8-7-6-5-4-5
    do_reset(1'b0);
    exp_st.push_back(7); exp_st.push_back(6);
    release_rst(7);
    hold(2000);
    step(5, 1, MRAZ, 1'b1); hold(3000);
    step(4, 0, MRAZ, 1'b0); hold(3000);
    step(5, 1, MRAZ, 1'b1); hold(3000);
    check("R8 idle after measure", int'(busy_o), 0);
    drained("R2 seqA");

    // B: 5-4-5-8-7-6-5, fallback on short phase
    step(4, 0, MRAZ, 1'b0); hold(3000);
    step(5, 1, 2 * MRAZ, 1'b1); hold(500);
    exp_st.push_back(8); exp_st.push_back(7); exp_st.push_back(6);
    exp_start.push_back(0);
    set_conv(1'b0); hold(4000);
    check("R4 queued start gap", start_gap, MRAZ);
    step(5, 1, MRAZ, 1'b1); hold(3000);
    drained("R4 seqB");

    // C: power-up high, 1-2-3-4-1-2-3-4 with hold in 1 and wait in 2
    do_reset(1'b1);
    exp_st.push_back(1); exp_st.push_back(2); exp_st.push_back(3);
    release_rst(0);
    hold(2000);
    step(4, 0, 2 * MRAZ, 1'b0); hold(400);
    step(1, 1, 0, 1'b1); hold(300);
    set_conv(1'b0); hold(50);
    check("R5 state 1 holds on conv low", int'(state_o), 0);
    hold(250);
    set_conv(1'b1); hold(300);
    exp_st.push_back(2);
    set_conv(1'b0); hold(3500);
    check("R5 state 2 waits for conv high", int'(state_o), 1);
    check("R4 queued start gap", start_gap, MRAZ);
    step(3, -1, 0, 1'b1); hold(100);
    step(4, 0, MRAZ, 1'b0); hold(3000);
    drained("R5 seqC");

    // D: mirror fallback 4-5-8-7-6-5 with conv toggling in 8
    step(5, 1, 2 * MRAZ, 1'b1); hold(200);
    step(8, 0, 0, 1'b0); hold(100);
    set_conv(1'b1); hold(100);
    check("R5 state 8 holds on conv high", int'(state_o), 7);
    exp_st.push_back(7); exp_st.push_back(6);
    set_conv(1'b0); hold(3500);
    step(5, 1, MRAZ, 1'b1); hold(3000);
    drained("R10 seqD");

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: got %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end
endmodule